// File: doc/BRIEF.md
# Byte-Align, Bit-Swap and Shift-Add ALU Slice

This block is a single-cycle integer ALU slice for a 32-bit datapath. It has four operations: a scaled-index add that shifts one operand left by one to four places before adding it to the other, a byte-granular funnel extract across two operands, a bit reversal done inside each byte, and an add of a 16-bit value placed in the upper half of the word. The decode stage presents the operation code, two operands, a 2-bit field that is either the scale or the byte position, and a 16-bit immediate, all together with a request strobe.

The result is captured in a register. A valid pulse comes out one clock after each request cycle. When no request is present the result register keeps its last value. The reset input asserts asynchronously and is released through a two-stage synchronizer, so the block accepts requests from the third rising edge after reset is removed.

Top module: `byteops_alu`

## Requirements
- R1: While `rst_n` is low, `res_o` is zero and `vld_o` is low, with no clock edge needed. Both remain so until the release has passed the two-stage synchronizer.
- R2: With `op_i` = 0 (scaled add), the result is `opb_i + (opa_i << (pos_i + 1))` modulo 2^32, so the shift runs from 1 to 4.
- R3: With `op_i` = 1 (align) and `pos_i` = 0, the result equals `opb_i` exactly, and no bit of `opa_i` appears in it.
- R4: With `op_i` = 1 and `pos_i` = p in 1..3, byte j of the result (byte 0 = bits 7:0) is byte j-p of `opb_i` for j >= p, and byte 4-p+j of `opa_i` for j < p.
- R5: With `op_i` = 2 (bit swap), each byte of `opb_i` has its bit order reversed in place (bit 8k+i goes to bit 8k+7-i), and the bytes do not change position.
- R6: With `op_i` = 3 (upper add), the result is `opa_i` plus the sign-extended `imm_i` shifted left by 16, modulo 2^32.
- R7: `vld_o` is high in exactly the cycle after a cycle in which `req_i` was high at the rising edge, and low otherwise.
- R8: When `req_i` is low, `res_o` holds its previous value whatever `op_i`, operands, `pos_i` and `imm_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe; operands are taken at the rising edge |
| op_i | input | 2 | Operation: 0 scaled add, 1 align, 2 bit swap, 3 upper add |
| opa_i | input | 32 | First operand: scaled value, low-side align source, upper-add base |
| opb_i | input | 32 | Second operand: add base, high-side align source, bit-swap source |
| pos_i | input | 2 | Scale minus one for scaled add, byte position for align |
| imm_i | input | 16 | Immediate for the upper add |
| res_o | output | 32 | Registered result |
| vld_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Every operation is swept over all four positions with corner operands (all ones, sign bits, alternating patterns) and generated words. Every byte value is sent through the bit swap in each byte lane. A design that reversed the whole word, or that let a shift by 32 leak `opa_i` into the align result at position zero, would return wrong bytes. So would a design that shifted by `pos_i` rather than `pos_i + 1`, or that dropped the sign of the immediate. The bench also checks that a result survives idle cycles with the inputs moving, and that a reset in the middle of a cycle clears the outputs at once. A design that updated the register on every edge, or used a synchronous clear, would fail those checks.

// File: rtl/byteops_pkg.sv
package byteops_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned FIELD_W = 2;
  localparam int unsigned IMMED_W = 16;

  typedef enum logic [1:0] {
    OP_SCALE = 2'd0,
    OP_ALIGN = 2'd1,
    OP_BSWAP = 2'd2,
    OP_UPPER = 2'd3
  } alu_op_e;
endpackage

// File: rtl/byteops_scaled_add.sv
module byteops_scaled_add #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = 2
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [POS_W-1:0]  sa_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int unsigned AMT_W = POS_W + 1;

  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] scaled;

  always_comb begin
    amt    = {1'b0, sa_i} + AMT_W'(1);
    scaled = idx_i << amt;
    sum_o  = base_i + scaled;
  end
endmodule

// File: rtl/byteops_align.sv
module byteops_align #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned POS_W  = 2
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [DATA_W-1:0] out_o
);
  localparam int unsigned CAT_W = 2 * DATA_W;
  localparam int unsigned SH_W  = $clog2(CAT_W);

  logic [CAT_W-1:0] joined;
  logic [SH_W-1:0]  sh;

  // A funnel over the concatenation: position zero is a shift of zero, so
  // no low-side bit can reach the upper half.
  always_comb begin
    sh     = SH_W'(pos_i) * SH_W'(BYTE_W);
    joined = {hi_i, lo_i} << sh;
    out_o  = joined[CAT_W-1:DATA_W];
  end
endmodule

// File: rtl/byteops_bitrev.sv
module byteops_bitrev #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GRP_W  = 8
) (
  input  logic [DATA_W-1:0] in_i,
  output logic [DATA_W-1:0] out_o
);
  localparam int unsigned STAGES = $clog2(GRP_W);

  function automatic logic [DATA_W-1:0] stage_mask(input int unsigned k);
    logic [DATA_W-1:0] m;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      m[i] = (((i >> k) & 1) == 0);
    end
    return m;
  endfunction

  logic [DATA_W-1:0] stg [0:STAGES];

  assign stg[0] = in_i;

  // Each stage swaps neighbouring groups of 2^k bits; after log2(GRP_W)
  // stages every lane of GRP_W bits is mirrored in place.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [DATA_W-1:0] MASK = stage_mask(k);
    localparam int unsigned       SH   = 1 << k;
    assign stg[k+1] = ((stg[k] >> SH) & MASK) | ((stg[k] & MASK) << SH);
  end

  assign out_o = stg[STAGES];
endmodule

// File: rtl/byteops_upper_add.sv
module byteops_upper_add #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] ext;

  always_comb begin
    ext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    sum_o = base_i + (ext << EXT_W);
  end
endmodule

// File: rtl/byteops_alu.sv
module byteops_alu
  import byteops_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned BYTE_W = LANE_W,
  parameter int unsigned POS_W  = FIELD_W,
  parameter int unsigned IMM_W  = IMMED_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              vld_o
);
  localparam int unsigned SYNC_N = 2;

  // Reset: asserted at once, released after SYNC_N rising edges.
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  // Operation datapaths.
  logic [DATA_W-1:0] scale_y, align_y, bswap_y, upper_y;

  byteops_scaled_add #(.DATA_W(DATA_W), .POS_W(POS_W)) u_scale (
    .base_i(opb_i), .idx_i(opa_i), .sa_i(pos_i), .sum_o(scale_y)
  );

  byteops_align #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .POS_W(POS_W)) u_align (
    .hi_i(opb_i), .lo_i(opa_i), .pos_i(pos_i), .out_o(align_y)
  );

  byteops_bitrev #(.DATA_W(DATA_W), .GRP_W(BYTE_W)) u_bswap (
    .in_i(opb_i), .out_o(bswap_y)
  );

  byteops_upper_add #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_upper (
    .base_i(opa_i), .imm_i(imm_i), .sum_o(upper_y)
  );

  // Next state.
  alu_op_e           op_sel;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;
  logic              res_en;

  always_comb begin
    op_sel = alu_op_e'(op_i);
    res_en = req_i;
    vld_d  = req_i;
    res_d  = res_q;
    if (res_en) begin
      unique case (op_sel)
        OP_SCALE: res_d = scale_y;
        OP_ALIGN: res_d = align_y;
        OP_BSWAP: res_d = bswap_y;
        OP_UPPER: res_d = upper_y;
        default:  res_d = res_q;
      endcase
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign res_o = res_q;
  assign vld_o = vld_q;

  // Assertions.
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_i |=> vld_o);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_i |=> !vld_o);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_i |=> $stable(res_o));

  a_r2_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && op_i == OP_SCALE) |=>
      ((res_o ^ $past(opb_i)) & ((DATA_W'(2) << $past(pos_i)) - DATA_W'(1))) == '0);

  a_r3_align_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && op_i == OP_ALIGN && pos_i == '0) |=> res_o == $past(opb_i));

  a_r5_ones_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && op_i == OP_BSWAP) |=> $countones(res_o) == $countones($past(opb_i)));

  a_r6_low_half: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && op_i == OP_UPPER) |=> res_o[IMM_W-1:0] == $past(opa_i[IMM_W-1:0]));
endmodule

// File: tb/sim_byteops_alu.sv
module sim_byteops_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [1:0]  op_i;
  logic [31:0] opa_i, opb_i;
  logic [1:0]  pos_i;
  logic [15:0] imm_i;
  logic [31:0] res_o;
  logic        vld_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  byteops_alu u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .pos_i(pos_i), .imm_i(imm_i),
    .res_o(res_o), .vld_o(vld_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [31:0] exp_scale(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] p);
    logic [63:0] full;
    full = {32'd0, b} + {32'd0, a} * (64'd1 << (int'(p) + 1));
    return full[31:0];
  endfunction

  function automatic logic [31:0] exp_align(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] p);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) begin
      if (j >= int'(p)) r[8*j +: 8] = b[8*(j-int'(p)) +: 8];
      else              r[8*j +: 8] = a[8*(4-int'(p)+j) +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_bswap(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[8*(i/8) + 7 - (i%8)] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] exp_upper(input logic [31:0] a, input logic [15:0] imm);
    int s;
    s = int'($signed(imm));
    return a + 32'(s * 65536);
  endfunction

  // Drive one request and check it in the cycle its result appears.
  task automatic run_op(input string tag, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [1:0] p, input logic [15:0] imm,
                        input logic [31:0] exp);
    @(negedge clk);
    req_i = 1'b1; op_i = op; opa_i = a; opb_i = b; pos_i = p; imm_i = imm;
    @(negedge clk);
    req_i = 1'b0;
    check(tag, res_o, exp);
    check("R7 valid pulse", {31'd0, vld_o}, 32'd1);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; req_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0; pos_i = '0; imm_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog R7 got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [31:0] corners [0:7];
    logic [31:0] a, b, hold_val;
    logic [15:0] imm;
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h5555_5555; corners[5] = 32'hAAAA_AAAA;
    corners[6] = 32'h0000_0001; corners[7] = 32'h1234_5678;

    rst_n = 1'b0; req_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0; pos_i = '0; imm_i = '0;
    #(CLK_PERIOD/4);
    check("R1 reset result", res_o, 32'd0);
    check("R1 reset valid", {31'd0, vld_o}, 32'd0);
    apply_reset();
    check("R7 idle valid", {31'd0, vld_o}, 32'd0);

    // R2 scaled add, every scale, corners and generated words
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op("R2 scaled add", 2'd0, corners[i], corners[j], 2'(p), 16'd0,
                 exp_scale(corners[i], corners[j], 2'(p)));
      for (int n = 0; n < 30; n++) begin
        a = next_rand(); b = next_rand();
        run_op("R2 scaled add", 2'd0, a, b, 2'(p), 16'd0, exp_scale(a, b, 2'(p)));
      end
    end

    // R3 align at position zero, R4 align at positions 1..3
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(p == 0 ? "R3 align zero" : "R4 align", 2'd1, corners[i], corners[j],
                 2'(p), 16'd0, exp_align(corners[i], corners[j], 2'(p)));
      for (int n = 0; n < 30; n++) begin
        a = next_rand(); b = next_rand();
        run_op(p == 0 ? "R3 align zero" : "R4 align", 2'd1, a, b, 2'(p), 16'd0,
               exp_align(a, b, 2'(p)));
      end
    end

    // R5 bit swap: every byte value in every lane, neighbours differing
    for (int v = 0; v < 256; v++) begin
      b = {8'(v), 8'(v ^ 8'h3C), 8'(255 - v), 8'(v * 7)};
      a = next_rand();
      run_op("R5 bit swap", 2'd2, a, b, 2'(v), 16'(v), exp_bswap(b));
    end
    for (int i = 0; i < 8; i++)
      run_op("R5 bit swap", 2'd2, 32'd0, corners[i], 2'd0, 16'd0, exp_bswap(corners[i]));

    // R6 upper add, both immediate signs
    for (int i = 0; i < 8; i++) begin
      run_op("R6 upper add", 2'd3, corners[i], 32'd0, 2'd0, 16'h8000,
             exp_upper(corners[i], 16'h8000));
      run_op("R6 upper add", 2'd3, corners[i], 32'd0, 2'd0, 16'h7FFF,
             exp_upper(corners[i], 16'h7FFF));
      run_op("R6 upper add", 2'd3, corners[i], 32'd0, 2'd0, 16'hFFFF,
             exp_upper(corners[i], 16'hFFFF));
    end
    for (int n = 0; n < 100; n++) begin
      a = next_rand(); imm = next_rand() >> 16;
      run_op("R6 upper add", 2'd3, a, next_rand(), 2'(n), imm, exp_upper(a, imm));
    end

    // R8 hold with moving inputs, R7 no pulse while idle
    run_op("R6 upper add", 2'd3, 32'h0BAD_F00D, 32'd0, 2'd0, 16'h0001,
           exp_upper(32'h0BAD_F00D, 16'h0001));
    hold_val = exp_upper(32'h0BAD_F00D, 16'h0001);
    for (int n = 0; n < 8; n++) begin
      op_i = 2'(n); opa_i = next_rand(); opb_i = next_rand(); pos_i = 2'(n); imm_i = 16'(n);
      @(negedge clk);
      check("R8 hold while idle", res_o, hold_val);
      check("R7 no pulse while idle", {31'd0, vld_o}, 32'd0);
    end

    // R7 back-to-back requests give a valid in each following cycle
    @(negedge clk);
    req_i = 1'b1; op_i = 2'd2; opb_i = 32'h0102_0408;
    @(negedge clk);
    check("R5 bit swap", res_o, exp_bswap(32'h0102_0408));
    check("R7 valid back to back", {31'd0, vld_o}, 32'd1);
    op_i = 2'd1; opa_i = 32'hAABB_CCDD; opb_i = 32'h1122_3344; pos_i = 2'd3;
    @(negedge clk);
    req_i = 1'b0;
    check("R4 align", res_o, exp_align(32'hAABB_CCDD, 32'h1122_3344, 2'd3));
    check("R7 valid back to back", {31'd0, vld_o}, 32'd1);
    @(negedge clk);
    check("R7 pulse ends", {31'd0, vld_o}, 32'd0);

    // R1 asynchronous clear mid-cycle
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1 async clear result", res_o, 32'd0);
    check("R1 async clear valid", {31'd0, vld_o}, 32'd0);
    apply_reset();
    run_op("R2 scaled add", 2'd0, 32'h4000_0001, 32'd5, 2'd3,
           16'd0, exp_scale(32'h4000_0001, 32'd5, 2'd3));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule